// File: doc/BRIEF.md
# Floating-Point Status Register Move Unit

This block carries out the family of instructions that copy the floating-point status and control register into a floating-point target register. Some of these instructions also change part of that register as a side effect. Each cycle it may receive one 32-bit instruction word together with three other inputs: a 64-bit source operand read from the FP register file, a flag saying whether the FPU is enabled, and a flag saying whether the newer instruction-set level is implemented. It decodes which of seven variants is meant. On the next clock edge it delivers a masked copy of the register with a target write enable and the target index. It can also deliver a 4-bit value for condition field 1.

The status and control register is held inside the block, and its current image is visible on `csr_value`. The rest of the FPU can load it through a separate write port. Variants that modify the register either clear the exception enables or replace one rounding-mode field. The replacement comes from the source operand or from an immediate in the instruction. The copy sent to the target register is always taken from the value before the same instruction's update. An illegal encoding or an unavailable FPU is reported as a one-cycle strobe, and the instruction then has no other effect.

Top module: `fpscr_move_unit`

## Requirements
- R1: An instruction is taken only when `instr_valid` is high, `instr[31:26]` is 111111 and `instr[10:1]` is 1001000111. Any other word produces no strobe, no write and no register change. The variant selector is `instr[20:16]`, the target index is `instr[25:21]`, and a selector outside the seven defined codes raises the illegal strobe.
- R2: The register image holds binary rounding mode in bits 1:0, non-IEEE mode in bit 2, exception enables in bits 7:3, status in bits 31:8 and decimal rounding mode in bits 34:32. All other bits always read zero. Reset clears the whole register. When `ext_wr_en` is high, the register loads `ext_wr_data` with the undefined bits forced to zero.
- R3: Selector 00000 (full read) returns the whole register and modifies nothing. When `instr[0]` is set, it also pulses `cr1_wr_en`, and `cr1_data` carries register bits 31:28.
- R4: Selector 11000 (light read) returns decimal rounding, status, enables, non-IEEE and binary rounding, and modifies nothing. `instr[0]` has no effect on condition field 1.
- R5: Selector 00001 returns the whole register, then clears bits 7:3 and leaves every other bit unchanged.
- R6: Selectors 10110, 10100, 10111 and 10101 return only bits 34:32 and 7:0. The status bits 31:8 read as zero in the result.
- R7: Selector 10110 replaces bits 1:0 with `src_opnd[1:0]`. Selector 10100 replaces bits 34:32 with `src_opnd[34:32]`. No other source bit has any effect.
- R8: Selector 10111 replaces bits 1:0 with `instr[12:11]`. Selector 10101 replaces bits 34:32 with `instr[13:11]`.
- R9: Every variant except the full read requires `isa_ext_en`. Without it the illegal strobe is raised, with no write and no register change.
- R10: With `fpu_on` low, an otherwise legal instruction raises `fpu_unavail_strb` with no write and no register change. When both conditions apply, the illegal strobe wins.
- R11: The result, the strobes and the register update all appear on the clock edge after the instruction is presented. The result reflects the register before that instruction's own update, and the strobes last one cycle.
- R12: If a modifying instruction and `ext_wr_en` arrive in the same cycle, the instruction's update wins. A non-modifying or rejected instruction lets the external write through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src_opnd | input | 64 | Source operand from the FP register file |
| fpu_on | input | 1 | FPU enabled |
| isa_ext_en | input | 1 | Newer instruction-set level present |
| ext_wr_en | input | 1 | Load the register from the rest of the FPU |
| ext_wr_data | input | 64 | Value for the external load |
| csr_value | output | 64 | Current register image |
| tgt_wr_en | output | 1 | Target register write enable |
| tgt_idx | output | 5 | Target register index |
| tgt_data | output | 64 | Value to write to the target register |
| cr1_wr_en | output | 1 | Condition field 1 write enable |
| cr1_data | output | 4 | Value for condition field 1 |
| illegal_strb | output | 1 | Illegal-instruction strobe |
| fpu_unavail_strb | output | 1 | FPU-unavailable strobe |

## Verification
Every variant is tried on an all-ones register image and on a mixed pattern. Against all-ones, a missing status mask or a lost field shows up at once. The mixed pattern tells apart a field placed at the wrong bit position and a clear that reaches a neighbouring field. The source operand is driven with all-ones and with alternating patterns in the bits outside the replaced field, so that any leak of stray source bits is visible. Modifying variants are issued back to back with reads, which separates the pre-update result from the updated register. Combinations of the ISA flag, the FPU flag, an unknown selector, a foreign opcode and a colliding external write show the priority between rejection, execution and the external load.

// File: rtl/fpscr_mv_pkg.sv
package fpscr_mv_pkg;

  localparam int XLEN    = 64;
  localparam int IW      = 32;
  localparam int RIDX_W  = 5;
  localparam int SEL_W   = 5;

  // Field placement inside the register image
  localparam int RN_LSB  = 0;
  localparam int RN_W    = 2;
  localparam int NI_LSB  = 2;
  localparam int NI_W    = 1;
  localparam int EN_LSB  = 3;
  localparam int EN_W    = 5;
  localparam int ST_LSB  = 8;
  localparam int ST_W    = 24;
  localparam int DRN_LSB = 32;
  localparam int DRN_W   = 3;
  localparam int SUM_LSB = 28;
  localparam int SUM_W   = 4;

  // Opcode fields
  localparam logic [5:0] PRI_OP = 6'b111111;
  localparam logic [9:0] EXT_OP = 10'b1001000111;

  localparam logic [SEL_W-1:0] SEL_FULL    = 5'b00000;
  localparam logic [SEL_W-1:0] SEL_LIGHT   = 5'b11000;
  localparam logic [SEL_W-1:0] SEL_CLREN   = 5'b00001;
  localparam logic [SEL_W-1:0] SEL_RN_REG  = 5'b10110;
  localparam logic [SEL_W-1:0] SEL_DRN_REG = 5'b10100;
  localparam logic [SEL_W-1:0] SEL_RN_IMM  = 5'b10111;
  localparam logic [SEL_W-1:0] SEL_DRN_IMM = 5'b10101;

  typedef enum logic [2:0] {
    V_FULL,
    V_LIGHT,
    V_CLREN,
    V_RN_REG,
    V_DRN_REG,
    V_RN_IMM,
    V_DRN_IMM,
    V_NONE
  } mv_var_e;

  function automatic logic [XLEN-1:0] fmask(input int lsb, input int w);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (i >= lsb && i < lsb + w) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [XLEN-1:0] M_RN  = fmask(RN_LSB, RN_W);
  localparam logic [XLEN-1:0] M_NI  = fmask(NI_LSB, NI_W);
  localparam logic [XLEN-1:0] M_EN  = fmask(EN_LSB, EN_W);
  localparam logic [XLEN-1:0] M_ST  = fmask(ST_LSB, ST_W);
  localparam logic [XLEN-1:0] M_DRN = fmask(DRN_LSB, DRN_W);
  localparam logic [XLEN-1:0] M_DEF = M_RN | M_NI | M_EN | M_ST | M_DRN;
  localparam logic [XLEN-1:0] M_LIGHT = M_DRN | M_ST | M_EN | M_NI | M_RN;
  localparam logic [XLEN-1:0] M_RMODE = M_DRN | M_EN | M_NI | M_RN;

endpackage

// File: rtl/fpscr_mv_decode.sv
module fpscr_mv_decode
  import fpscr_mv_pkg::*;
#(
  parameter int IWID = IW
) (
  input  logic                instr_valid,
  input  logic [IWID-1:0]     instr,
  input  logic                fpu_on,
  input  logic                isa_ext_en,
  output mv_var_e             variant,
  output logic                accept,
  output logic                illegal,
  output logic                unavail,
  output logic                rec_en,
  output logic [RIDX_W-1:0]   rt,
  output logic [DRN_W-1:0]    imm
);

  localparam int PRI_HI = IWID - 1;
  localparam int PRI_LO = IWID - 6;
  localparam int RT_LO  = PRI_LO - RIDX_W;
  localparam int SEL_LO = RT_LO - SEL_W;
  localparam int RB_LO  = SEL_LO - RIDX_W;

  logic              is_ours;
  logic              known;
  logic              isa_bad;
  logic [SEL_W-1:0]  sel;
  logic              unused_rb_hi;

  assign sel    = instr[RT_LO-1:SEL_LO];
  assign rt     = instr[PRI_LO-1:RT_LO];
  assign imm    = instr[RB_LO+DRN_W-1:RB_LO];
  assign unused_rb_hi = ^instr[SEL_LO-1:RB_LO+DRN_W];

  assign is_ours = instr_valid
                 && (instr[PRI_HI:PRI_LO] == PRI_OP)
                 && (instr[10:1] == EXT_OP);

  always_comb begin
    known = 1'b1;
    unique case (sel)
      SEL_FULL:    variant = V_FULL;
      SEL_LIGHT:   variant = V_LIGHT;
      SEL_CLREN:   variant = V_CLREN;
      SEL_RN_REG:  variant = V_RN_REG;
      SEL_DRN_REG: variant = V_DRN_REG;
      SEL_RN_IMM:  variant = V_RN_IMM;
      SEL_DRN_IMM: variant = V_DRN_IMM;
      default: begin
        variant = V_NONE;
        known   = 1'b0;
      end
    endcase
  end

  assign isa_bad = (variant != V_FULL) && !isa_ext_en;

  always_comb begin
    illegal = 1'b0;
    unavail = 1'b0;
    accept  = 1'b0;
    if (is_ours) begin
      if (!known || isa_bad) illegal = 1'b1;
      else if (!fpu_on)      unavail = 1'b1;
      else                   accept  = 1'b1;
    end
  end

  assign rec_en = accept && (variant == V_FULL) && instr[0];

endmodule

// File: rtl/fpscr_mv_update.sv
module fpscr_mv_update
  import fpscr_mv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  mv_var_e          variant,
  input  logic [W-1:0]     csr,
  input  logic [W-1:0]     src,
  input  logic [DRN_W-1:0] imm,
  output logic [W-1:0]     rd_val,
  output logic [W-1:0]     nxt_val,
  output logic             modifies
);

  logic [W-1:0] rd_mask;
  logic [W-1:0] clr_mask;
  logic [W-1:0] rep_mask;
  logic [W-1:0] rep_val;
  logic [W-1:0] imm_rn;
  logic [W-1:0] imm_drn;

  always_comb begin
    imm_rn  = '0;
    imm_drn = '0;
    imm_rn[RN_LSB +: RN_W]    = imm[RN_W-1:0];
    imm_drn[DRN_LSB +: DRN_W] = imm;
  end

  always_comb begin
    rd_mask  = '0;
    clr_mask = '0;
    rep_mask = '0;
    rep_val  = '0;
    modifies = 1'b0;
    unique case (variant)
      V_FULL:  rd_mask = '1;
      V_LIGHT: rd_mask = M_LIGHT;
      V_CLREN: begin
        rd_mask  = '1;
        clr_mask = M_EN;
        modifies = 1'b1;
      end
      V_RN_REG: begin
        rd_mask  = M_RMODE;
        rep_mask = M_RN;
        rep_val  = src;
        modifies = 1'b1;
      end
      V_DRN_REG: begin
        rd_mask  = M_RMODE;
        rep_mask = M_DRN;
        rep_val  = src;
        modifies = 1'b1;
      end
      V_RN_IMM: begin
        rd_mask  = M_RMODE;
        rep_mask = M_RN;
        rep_val  = imm_rn;
        modifies = 1'b1;
      end
      V_DRN_IMM: begin
        rd_mask  = M_RMODE;
        rep_mask = M_DRN;
        rep_val  = imm_drn;
        modifies = 1'b1;
      end
      default: ;
    endcase
  end

  assign rd_val = csr & rd_mask;

  // Per-bit merge: replace, clear, or keep
  for (genvar b = 0; b < W; b++) begin : g_merge
    always_comb begin
      if (rep_mask[b])      nxt_val[b] = rep_val[b];
      else if (clr_mask[b]) nxt_val[b] = 1'b0;
      else                  nxt_val[b] = csr[b];
    end
  end

endmodule

// File: rtl/fpscr_move_unit.sv
module fpscr_move_unit
  import fpscr_mv_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int IWID = IW,
  parameter int RW   = RIDX_W,
  parameter int CRW  = SUM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [IWID-1:0]  instr,
  input  logic [W-1:0]     src_opnd,
  input  logic             fpu_on,
  input  logic             isa_ext_en,
  input  logic             ext_wr_en,
  input  logic [W-1:0]     ext_wr_data,
  output logic [W-1:0]     csr_value,
  output logic             tgt_wr_en,
  output logic [RW-1:0]    tgt_idx,
  output logic [W-1:0]     tgt_data,
  output logic             cr1_wr_en,
  output logic [CRW-1:0]   cr1_data,
  output logic             illegal_strb,
  output logic             fpu_unavail_strb
);

  mv_var_e          variant;
  logic             accept;
  logic             illegal_c;
  logic             unavail_c;
  logic             rec_en;
  logic [RW-1:0]    rt_c;
  logic [DRN_W-1:0] imm_c;
  logic [W-1:0]     rd_val;
  logic [W-1:0]     nxt_val;
  logic             modifies;
  logic [W-1:0]     csr_q;
  logic             upd_en;

  fpscr_mv_decode #(.IWID(IWID)) u_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .fpu_on      (fpu_on),
    .isa_ext_en  (isa_ext_en),
    .variant     (variant),
    .accept      (accept),
    .illegal     (illegal_c),
    .unavail     (unavail_c),
    .rec_en      (rec_en),
    .rt          (rt_c),
    .imm         (imm_c)
  );

  fpscr_mv_update #(.W(W)) u_upd (
    .variant  (variant),
    .csr      (csr_q),
    .src      (src_opnd),
    .imm      (imm_c),
    .rd_val   (rd_val),
    .nxt_val  (nxt_val),
    .modifies (modifies)
  );

  assign upd_en = accept && modifies;

  // Status/control register: instruction update beats external load
  always_ff @(posedge clk) begin
    if (rst)            csr_q <= '0;
    else if (upd_en)    csr_q <= nxt_val & M_DEF;
    else if (ext_wr_en) csr_q <= ext_wr_data & M_DEF;
  end

  assign csr_value = csr_q;

  // Registered results, taken from the pre-update image
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_wr_en        <= 1'b0;
      tgt_idx          <= '0;
      tgt_data         <= '0;
      cr1_wr_en        <= 1'b0;
      cr1_data         <= '0;
      illegal_strb     <= 1'b0;
      fpu_unavail_strb <= 1'b0;
    end else begin
      tgt_wr_en        <= accept;
      tgt_idx          <= accept ? rt_c : '0;
      tgt_data         <= accept ? rd_val : '0;
      cr1_wr_en        <= rec_en;
      cr1_data         <= rec_en ? csr_q[SUM_LSB +: CRW] : '0;
      illegal_strb     <= illegal_c;
      fpu_unavail_strb <= unavail_c;
    end
  end

  // R11: at most one outcome per instruction
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tgt_wr_en, illegal_strb, fpu_unavail_strb}));

  // R3: condition field only alongside a target write
  a_r3_cr1_with_write: assert property (@(posedge clk) disable iff (rst)
    cr1_wr_en |-> tgt_wr_en);

  // R2: undefined bits stay zero
  a_r2_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (csr_q & ~M_DEF) == '0);

  // R5: enables are clear after the clear-enables variant
  a_r5_enables_cleared: assert property (@(posedge clk) disable iff (rst)
    (accept && variant == V_CLREN) |=> (csr_q[EN_LSB +: EN_W] == '0));

  // R6: status masked in rounding-mode results
  a_r6_status_masked: assert property (@(posedge clk) disable iff (rst)
    (accept && (variant == V_RN_REG || variant == V_DRN_REG ||
                variant == V_RN_IMM || variant == V_DRN_IMM))
    |=> (tgt_data[ST_LSB +: ST_W] == '0));

  // R9/R10: rejected instructions leave the register alone
  a_r9_reject_no_change: assert property (@(posedge clk) disable iff (rst)
    ((illegal_c || unavail_c) && !ext_wr_en) |=> $stable(csr_q));

  // R4: reads without side effect keep the register
  a_r4_read_no_change: assert property (@(posedge clk) disable iff (rst)
    (accept && (variant == V_FULL || variant == V_LIGHT) && !ext_wr_en)
    |=> $stable(csr_q));

endmodule

// File: tb/fpscr_move_unit_bench.sv
module fpscr_move_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr;
  logic [63:0] src_opnd;
  logic        fpu_on;
  logic        isa_ext_en;
  logic        ext_wr_en;
  logic [63:0] ext_wr_data;
  logic [63:0] csr_value;
  logic        tgt_wr_en;
  logic [4:0]  tgt_idx;
  logic [63:0] tgt_data;
  logic        cr1_wr_en;
  logic [3:0]  cr1_data;
  logic        illegal_strb;
  logic        fpu_unavail_strb;

  always #10 clk = ~clk;

  fpscr_move_unit u_fpscr_move_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .src_opnd(src_opnd), .fpu_on(fpu_on), .isa_ext_en(isa_ext_en),
    .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data),
    .csr_value(csr_value), .tgt_wr_en(tgt_wr_en), .tgt_idx(tgt_idx),
    .tgt_data(tgt_data), .cr1_wr_en(cr1_wr_en), .cr1_data(cr1_data),
    .illegal_strb(illegal_strb), .fpu_unavail_strb(fpu_unavail_strb)
  );

  typedef struct {
    logic        we;
    logic [4:0]  rt;
    logic [63:0] data;
    logic        cwe;
    logic [3:0]  cr;
    logic        ill;
    logic        una;
    logic [63:0] csr;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] m_csr;
  int          checks   = 0;
  int          failures = 0;
  bit          done     = 0;

  localparam logic [63:0] DEF   = 64'h0000_0007_FFFF_FFFF;
  localparam logic [63:0] RMODE = 64'h0000_0007_0000_00FF;
  localparam logic [63:0] ENM   = 64'h0000_0000_0000_00F8;
  localparam logic [63:0] DRNM  = 64'h0000_0007_0000_0000;

  function automatic logic [31:0] mk(input logic [4:0] sel, input logic [4:0] rb,
                                     input logic [4:0] rt, input logic rc);
    return {6'b111111, rt, sel, rb, 10'b1001000111, rc};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: present one cycle of stimulus and queue what must come out
  task automatic issue(input logic v, input logic [31:0] ins, input logic [63:0] src,
                       input logic fe, input logic isa, input logic xw,
                       input logic [63:0] xd, input string req);
    exp_t e;
    logic [4:0]  sel;
    logic [63:0] nxt;
    bit mine, known, mod;
    sel = ins[20:16];
    e.we = 0; e.rt = '0; e.data = '0; e.cwe = 0; e.cr = '0;
    e.ill = 0; e.una = 0; e.req = req;
    mine  = v && ins[31:26] == 6'b111111 && ins[10:1] == 10'b1001000111;
    known = sel inside {5'b00000, 5'b11000, 5'b00001, 5'b10110,
                        5'b10100, 5'b10111, 5'b10101};
    mod = 0;
    nxt = m_csr;
    if (mine) begin
      if (!known || (sel != 5'b00000 && !isa)) e.ill = 1;
      else if (!fe) e.una = 1;
      else begin
        e.we = 1;
        e.rt = ins[25:21];
        case (sel)
          5'b00000: begin
            e.data = m_csr;
            e.cwe  = ins[0];
            e.cr   = ins[0] ? m_csr[31:28] : 4'h0;
          end
          5'b11000: e.data = m_csr & DEF;
          5'b00001: begin e.data = m_csr; nxt = m_csr & ~ENM; mod = 1; end
          5'b10110: begin e.data = m_csr & RMODE; nxt[1:0] = src[1:0]; mod = 1; end
          5'b10100: begin e.data = m_csr & RMODE; nxt[34:32] = src[34:32]; mod = 1; end
          5'b10111: begin e.data = m_csr & RMODE; nxt[1:0] = ins[12:11]; mod = 1; end
          default:  begin e.data = m_csr & RMODE; nxt[34:32] = ins[13:11]; mod = 1; end
        endcase
      end
    end
    if (mod) m_csr = nxt;
    else if (xw) m_csr = xd & DEF;
    e.csr = m_csr;
    @(negedge clk);
    instr_valid = v; instr = ins; src_opnd = src; fpu_on = fe;
    isa_ext_en = isa; ext_wr_en = xw; ext_wr_data = xd;
    @(posedge clk);
    #1;
    sb.push_back(e);
  endtask

  task automatic idle(input string req);
    issue(1'b0, 32'h0, 64'h0, 1'b1, 1'b1, 1'b0, 64'h0, req);
  endtask

  task automatic load(input logic [63:0] d, input string req);
    issue(1'b0, 32'h0, 64'h0, 1'b1, 1'b1, 1'b1, d, req);
  endtask

  task automatic run(input logic [31:0] ins, input logic [63:0] src, input string req);
    issue(1'b1, ins, src, 1'b1, 1'b1, 1'b0, 64'h0, req);
  endtask

  // Monitor: compare one queued item per cycle
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(tgt_wr_en == e.we, e.req, "tgt_wr_en", 64'(tgt_wr_en), 64'(e.we));
      chk(tgt_idx == e.rt, e.req, "tgt_idx", 64'(tgt_idx), 64'(e.rt));
      chk(tgt_data == e.data, e.req, "tgt_data", tgt_data, e.data);
      chk(cr1_wr_en == e.cwe, e.req, "cr1_wr_en", 64'(cr1_wr_en), 64'(e.cwe));
      chk(cr1_data == e.cr, e.req, "cr1_data", 64'(cr1_data), 64'(e.cr));
      chk(illegal_strb == e.ill, e.req, "illegal_strb", 64'(illegal_strb), 64'(e.ill));
      chk(fpu_unavail_strb == e.una, e.req, "fpu_unavail_strb",
          64'(fpu_unavail_strb), 64'(e.una));
      chk(csr_value == e.csr, e.req, "csr_value", csr_value, e.csr);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_csr = '0;
    rst = 1; instr_valid = 0; instr = '0; src_opnd = '0; fpu_on = 1;
    isa_ext_en = 1; ext_wr_en = 0; ext_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk(csr_value == 64'h0, "R2", "reset csr", csr_value, 64'h0);
    chk(!tgt_wr_en && !illegal_strb && !fpu_unavail_strb && !cr1_wr_en,
        "R2", "reset strobes", 64'({tgt_wr_en, illegal_strb, fpu_unavail_strb, cr1_wr_en}), 64'h0);
    rst = 0;

    // R2: external load masks undefined bits
    load(64'hFFFF_FFFF_FFFF_FFFF, "R2");
    // R3: full read with and without record bit
    run(mk(5'b00000, 5'd0, 5'd5, 1'b0), 64'h0, "R3");
    run(mk(5'b00000, 5'd0, 5'd9, 1'b1), 64'h0, "R3");
    // R4: light read, record bit ignored
    run(mk(5'b11000, 5'd0, 5'd1, 1'b1), 64'h0, "R4");
    // R6: rounding variants mask status on all-ones image
    run(mk(5'b10111, 5'b00011, 5'd2, 1'b0), 64'h0, "R6");
    // R2: mixed pattern
    load(64'hA5A5_0005_9C3B_6A4D, "R2");
    run(mk(5'b00000, 5'd0, 5'd31, 1'b1), 64'h0, "R3");
    run(mk(5'b11000, 5'd0, 5'd3, 1'b0), 64'h0, "R4");
    // R5: clear enables, then read back
    run(mk(5'b00001, 5'd0, 5'd4, 1'b0), 64'h0, "R5");
    run(mk(5'b00000, 5'd0, 5'd4, 1'b0), 64'h0, "R5");
    // R7: register-sourced, stray source bits
    run(mk(5'b10110, 5'd7, 5'd6, 1'b0), 64'hFFFF_FFF8_FFFF_FFFE, "R7");
    run(mk(5'b10110, 5'd7, 5'd6, 1'b0), 64'h5555_5555_5555_5555, "R7");
    run(mk(5'b10100, 5'd7, 5'd8, 1'b0), 64'hAAAA_AAAA_AAAA_AAAA, "R7");
    run(mk(5'b10100, 5'd7, 5'd8, 1'b0), 64'hFFFF_FFF8_FFFF_FFFF, "R7");
    // R8: immediates, upper slot bits set to catch wrong slicing
    run(mk(5'b10111, 5'b11110, 5'd10, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    run(mk(5'b10101, 5'b11101, 5'd11, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    run(mk(5'b10101, 5'b01010, 5'd11, 1'b0), 64'h0, "R8");
    // R11: back-to-back update then read (pre-update result, then new value)
    run(mk(5'b10111, 5'b00001, 5'd12, 1'b0), 64'h0, "R11");
    run(mk(5'b10111, 5'b00010, 5'd12, 1'b0), 64'h0, "R11");
    run(mk(5'b00000, 5'd0, 5'd12, 1'b0), 64'h0, "R11");
    idle("R11");
    // R9: newer-level variants without the flag
    issue(1, mk(5'b11000, 5'd0, 5'd1, 1'b0), 64'h0, 1, 0, 0, 64'h0, "R9");
    issue(1, mk(5'b00001, 5'd0, 5'd1, 1'b0), 64'h0, 1, 0, 0, 64'h0, "R9");
    issue(1, mk(5'b10101, 5'b00111, 5'd1, 1'b0), 64'h0, 1, 0, 0, 64'h0, "R9");
    issue(1, mk(5'b00000, 5'd0, 5'd1, 1'b1), 64'h0, 1, 0, 0, 64'h0, "R9");
    // R10: FPU disabled, and priority of illegal
    issue(1, mk(5'b00000, 5'd0, 5'd1, 1'b1), 64'h0, 0, 1, 0, 64'h0, "R10");
    issue(1, mk(5'b10110, 5'd0, 5'd1, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 64'h0, "R10");
    issue(1, mk(5'b00001, 5'd0, 5'd1, 1'b0), 64'h0, 0, 0, 0, 64'h0, "R10");
    // R1: unknown selector, foreign opcodes, invalid slot
    run(mk(5'b01010, 5'd0, 5'd1, 1'b0), 64'h0, "R1");
    run({6'b111011, 5'd1, 5'b00001, 5'd0, 10'b1001000111, 1'b0}, 64'h0, "R1");
    run({6'b111111, 5'd1, 5'b00001, 5'd0, 10'b1001000110, 1'b0}, 64'h0, "R1");
    issue(0, mk(5'b00001, 5'd0, 5'd1, 1'b0), 64'h0, 1, 1, 0, 64'h0, "R1");
    // R12: collisions with the external load
    issue(1, mk(5'b10111, 5'b00011, 5'd2, 1'b0), 64'h0, 1, 1, 1, 64'h0000_0000_1234_5600, "R12");
    issue(1, mk(5'b00000, 5'd0, 5'd2, 1'b0), 64'h0, 1, 1, 1, 64'h0000_0003_8765_4321, "R12");
    issue(1, mk(5'b00001, 5'd0, 5'd2, 1'b0), 64'h0, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R12");
    run(mk(5'b00001, 5'd0, 5'd2, 1'b0), 64'h0, "R5");
    idle("R12");
    idle("R12");
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule